// File: doc/BRIEF.md
# Pipelined Butterfly Memory Request Network

This block carries memory requests from N processor ports to N shared-memory banks. It is not a crossbar. The requests pass through log2(N) columns of 2x2 routing switches. Each switch is pure combinational logic, and a register column follows every switch column. A switch steers a request up or down using one bit of the target bank number, starting with the most significant bit. After the last column, the request sits on the row of its bank. The bank index is the low bits of the word address, so consecutive words fall on different banks.

Two requests can want the same output of one switch in the same cycle. One of them goes forward and the other is dropped. A single priority flag decides which one goes forward, and it flips every cycle. Every request gets a response on its own port after exactly the same number of cycles. The response is an ACK with the word the bank returned, or a NACK if the request was dropped on the way. Each response echoes the tag the processor attached, so the processor can match it and reissue a NACKed access.

The bank model is a plain word array. A read returns the stored word. A write returns the word that was there before and then stores the new data. With N = 8 the latency is four cycles: three switch columns plus the bank register.

Top module: `mem_butterfly_net`

## Requirements
- R1: A request presented in cycle t gets exactly one response on its own port in cycle t+4 (rsp_valid high). A port that issued nothing in cycle t shows no response in cycle t+4. No response appears in the first four cycles after reset.
- R2: The response tag equals the tag of the request it answers. rsp_ack is never high without rsp_valid.
- R3: The bank is addr[2:0] and the word within the bank is addr[6:3]. A read ACK returns the last value written to that address, or zero if the address has not been written since reset.
- R4: A write ACK returns the previous contents of the address and stores the new data.
- R5: A request issued alone in its cycle is always ACKed.
- R6: When port p targets bank p for every p in the same cycle, all eight requests are ACKed.
- R7: When two requests collide, one is ACKed and one is NACKed. A NACKed write leaves the memory unchanged.
- R8: The priority flag is 0 until the first clock edge after reset release. After the n-th edge it equals n mod 2. A collision decided in column s for a request issued after edge n uses the flag value (n+s) mod 2. With flag 0, the input whose current row has the routing bit clear wins. For a port pair (0,x), that input is the one from port 0.
- R9: Requests for different banks that need the same switch output block each other. For example, ports 0 and 4 targeting banks 1 and 3 in the same cycle give one NACK.
- R10: Under random traffic from all ports, with every NACK retried, every access eventually completes. Its data matches a reference memory, and every response arrives at the fixed latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N | Request strobe per port |
| req_we | input | N | Write flag per port |
| req_addr | input | N x (log2 N + IDX_W) | Word address per port; low bits select the bank |
| req_wdata | input | N x DW | Write data per port |
| req_tag | input | N x TAG_W | Processor tag per port |
| rsp_valid | output | N | Response strobe, four cycles after the request |
| rsp_ack | output | N | 1 = ACK, 0 = NACK (retry) |
| rsp_tag | output | N x TAG_W | Echoed tag |
| rsp_rdata | output | N x DW | Read data, or old contents for a write |

## Verification
The bench forces collisions in the first, middle and last switch columns, with both priority phases in each. A design that used one global priority for every column would crown the wrong winner in the middle column. A design that lost track of the dropped request would show two ACKs or no response at all. A write that loses a collision is followed by a readback. This catches a switch that lets a NACKed write reach the bank. The bench also drives the identity permutation, which must pass without loss. It drives a pair that blocks inside the network although the two banks differ, which a design that only arbitrates at the banks would miss. Random traffic with retries then checks read-before-write data against a reference memory and checks the exact arrival cycle of every response.

// File: rtl/mbn_pkg.sv
package mbn_pkg;

    localparam int NET_PORTS = 8;
    localparam int NET_DW    = 32;
    localparam int NET_IDX_W = 4;
    localparam int NET_TAG_W = 4;
    localparam int NET_SEL_W = $clog2(NET_PORTS);

    // Default request packet; the top rebuilds it from its own parameters.
    typedef struct packed {
        logic                 valid;
        logic                 we;
        logic [NET_SEL_W-1:0] src;
        logic [NET_SEL_W-1:0] bank;
        logic [NET_IDX_W-1:0] idx;
        logic [NET_DW-1:0]    wdata;
    } net_pkt_t;

endpackage

// File: rtl/mbn_switch.sv
// 2x2 routing element: steers on one bank bit, drops the loser of a clash.
module mbn_switch #(
    parameter type PKT_T = mbn_pkg::net_pkt_t,
    parameter int  BIT   = 0
) (
    input  logic prio,
    input  PKT_T in_up,
    input  PKT_T in_lo,
    output PKT_T out_lo_row,
    output PKT_T out_hi_row
);

    logic up_dir, lo_dir, clash, keep_up, keep_lo;

    always_comb begin
        up_dir  = in_up.bank[BIT];
        lo_dir  = in_lo.bank[BIT];
        clash   = in_up.valid && in_lo.valid && (up_dir == lo_dir);
        keep_up = in_up.valid && (!clash || !prio);
        keep_lo = in_lo.valid && (!clash || prio);

        out_lo_row = '0;
        out_hi_row = '0;
        if (keep_up) begin
            if (up_dir) out_hi_row = in_up;
            else        out_lo_row = in_up;
        end
        if (keep_lo) begin
            if (lo_dir) out_hi_row = in_lo;
            else        out_lo_row = in_lo;
        end
    end

endmodule

// File: rtl/mbn_bank.sv
// One memory bank: read-before-write, registered response.
module mbn_bank #(
    parameter type PKT_T   = mbn_pkg::net_pkt_t,
    parameter int  DW      = 32,
    parameter int  IDX_W   = 4,
    parameter int  SRC_W   = 3,
    parameter int  BANK_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  PKT_T             req,
    output logic             rsp_valid,
    output logic [SRC_W-1:0] rsp_src,
    output logic [DW-1:0]    rsp_data
);

    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic                     vld;
        logic [SRC_W-1:0]         src;
        logic [DW-1:0]            data;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic     hit;

    always_comb begin
        st_d     = st_q;
        hit      = req.valid && (req.bank == SRC_W'(BANK_ID));
        st_d.vld = hit;
        st_d.src = req.src;
        st_d.data = hit ? st_q.mem[req.idx] : '0;
        if (hit && req.we) begin
            st_d.mem[req.idx] = req.wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.vld;
    assign rsp_src   = st_q.src;
    assign rsp_data  = st_q.data;

endmodule

// File: rtl/mem_butterfly_net.sv
module mem_butterfly_net import mbn_pkg::*; #(
    parameter int N     = NET_PORTS,
    parameter int DW    = NET_DW,
    parameter int IDX_W = NET_IDX_W,
    parameter int TAG_W = NET_TAG_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [N-1:0]                     req_valid,
    input  logic [N-1:0]                     req_we,
    input  logic [N-1:0][$clog2(N)+IDX_W-1:0] req_addr,
    input  logic [N-1:0][DW-1:0]             req_wdata,
    input  logic [N-1:0][TAG_W-1:0]          req_tag,
    output logic [N-1:0]                     rsp_valid,
    output logic [N-1:0]                     rsp_ack,
    output logic [N-1:0][TAG_W-1:0]          rsp_tag,
    output logic [N-1:0][DW-1:0]             rsp_rdata
);

    localparam int S      = $clog2(N);
    localparam int ADDR_W = S + IDX_W;
    localparam int LAT    = S + 1;

    typedef struct packed {
        logic             valid;
        logic             we;
        logic [S-1:0]     src;
        logic [S-1:0]     bank;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    wdata;
    } pkt_t;

    typedef struct packed {
        logic                                prio;
        logic [S-1:0][N-1:0][$bits(pkt_t)-1:0] stg;
        logic [LAT-1:0][N-1:0]               pv;
        logic [LAT-1:0][N-1:0][TAG_W-1:0]    pt;
    } state_t;

    state_t st_d, st_q;

    pkt_t sw_in  [S][N];
    pkt_t sw_out [S][N];

    // Column inputs: ports feed column 0, registers feed the rest.
    always_comb begin
        for (int p = 0; p < N; p++) begin
            sw_in[0][p].valid = req_valid[p];
            sw_in[0][p].we    = req_we[p];
            sw_in[0][p].src   = S'(p);
            sw_in[0][p].bank  = req_addr[p][S-1:0];
            sw_in[0][p].idx   = req_addr[p][ADDR_W-1:S];
            sw_in[0][p].wdata = req_wdata[p];
        end
        for (int s = 1; s < S; s++) begin
            for (int p = 0; p < N; p++) begin
                sw_in[s][p] = pkt_t'(st_q.stg[s-1][p]);
            end
        end
    end

    // Butterfly: column s pairs rows that differ in bit S-1-s.
    for (genvar s = 0; s < S; s++) begin : g_col
        localparam int K = S - 1 - s;
        for (genvar j = 0; j < N / 2; j++) begin : g_sw
            localparam int LO = ((j >> K) << (K + 1)) | (j & ((1 << K) - 1));
            localparam int HI = LO | (1 << K);
            mbn_switch #(
                .PKT_T (pkt_t),
                .BIT   (K)
            ) u_sw (
                .prio       (st_q.prio),
                .in_up      (sw_in[s][LO]),
                .in_lo      (sw_in[s][HI]),
                .out_lo_row (sw_out[s][LO]),
                .out_hi_row (sw_out[s][HI])
            );
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.prio = ~st_q.prio;
        for (int s = 0; s < S; s++) begin
            for (int p = 0; p < N; p++) begin
                st_d.stg[s][p] = sw_out[s][p];
            end
        end
        st_d.pv[0] = req_valid;
        st_d.pt[0] = req_tag;
        for (int i = 1; i < LAT; i++) begin
            st_d.pv[i] = st_q.pv[i-1];
            st_d.pt[i] = st_q.pt[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [N-1:0]          bk_vld;
    logic [N-1:0][S-1:0]   bk_src;
    logic [N-1:0][DW-1:0]  bk_data;

    for (genvar b = 0; b < N; b++) begin : g_bank
        mbn_bank #(
            .PKT_T   (pkt_t),
            .DW      (DW),
            .IDX_W   (IDX_W),
            .SRC_W   (S),
            .BANK_ID (b)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .req       (pkt_t'(st_q.stg[S-1][b])),
            .rsp_valid (bk_vld[b]),
            .rsp_src   (bk_src[b]),
            .rsp_data  (bk_data[b])
        );
    end

    // Return path: a bank answer goes to the port named in the packet.
    always_comb begin
        for (int p = 0; p < N; p++) begin
            rsp_ack[p]   = 1'b0;
            rsp_rdata[p] = '0;
            for (int b = 0; b < N; b++) begin
                if (bk_vld[b] && (bk_src[b] == S'(p))) begin
                    rsp_ack[p]   = 1'b1;
                    rsp_rdata[p] = rsp_rdata[p] | bk_data[b];
                end
            end
        end
    end

    assign rsp_valid = st_q.pv[LAT-1];
    assign rsp_tag   = st_q.pt[LAT-1];

endmodule

// File: rtl/mbn_net_chk.sv
module mbn_net_chk #(
    parameter int N     = 8,
    parameter int TAG_W = 4,
    parameter int LAT   = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [N-1:0]            req_valid,
    input logic [N-1:0][TAG_W-1:0] req_tag,
    input logic [N-1:0]            rsp_valid,
    input logic [N-1:0]            rsp_ack,
    input logic [N-1:0][TAG_W-1:0] rsp_tag
);

    int unsigned cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= 0;
        else if (cnt < LAT)  cnt <= cnt + 1;
    end

    a_r1_quiet_start: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt < LAT) |-> (rsp_valid == '0));

    a_r1_fixed_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt >= LAT) |-> (rsp_valid == $past(req_valid, LAT)));

    a_r2_ack_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsp_ack & ~rsp_valid) == '0));

    a_r5_lone_acked: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt >= LAT) && ($countones($past(req_valid, LAT)) == 1))
            |-> (rsp_ack == $past(req_valid, LAT)));

    for (genvar p = 0; p < N; p++) begin : g_port
        a_r2_tag_echo: assert property (@(posedge clk) disable iff (!rst_n)
            ((cnt >= LAT) && rsp_valid[p]) |-> (rsp_tag[p] == $past(req_tag[p], LAT)));
    end

endmodule

bind mem_butterfly_net mbn_net_chk #(
    .N     (N),
    .TAG_W (TAG_W),
    .LAT   (LAT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_tag   (req_tag),
    .rsp_valid (rsp_valid),
    .rsp_ack   (rsp_ack),
    .rsp_tag   (rsp_tag)
);

// File: tb/tb_mem_butterfly_net.sv
`timescale 1ns/1ps
module tb_mem_butterfly_net;

    localparam int N = 8, DW = 32, IDX_W = 4, TAG_W = 4;
    localparam int AW = 7, LAT = 4, OPS = 60;

    logic clk = 0, rst_n = 0;
    logic [N-1:0]            req_valid = '0, req_we = '0;
    logic [N-1:0][AW-1:0]    req_addr = '0;
    logic [N-1:0][DW-1:0]    req_wdata = '0;
    logic [N-1:0][TAG_W-1:0] req_tag = '0;
    logic [N-1:0]            rsp_valid, rsp_ack;
    logic [N-1:0][TAG_W-1:0] rsp_tag;
    logic [N-1:0][DW-1:0]    rsp_rdata;

    mem_butterfly_net dut (.*);

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    int nchk = 0, nerr = 0;
    logic [DW-1:0]    ref_mem [128];
    logic [TAG_W-1:0] tg = '0;

    typedef struct packed {
        logic [2:0]    port;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
        logic [DW-1:0] exp;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{3'd0, 1'b1, 7'h05, 32'hA1A1_0001, 32'h0},
        '{3'd3, 1'b0, 7'h05, 32'h0,         32'hA1A1_0001},
        '{3'd7, 1'b1, 7'h05, 32'hB2B2_0002, 32'hA1A1_0001},
        '{3'd5, 1'b0, 7'h05, 32'h0,         32'hB2B2_0002},
        '{3'd2, 1'b1, 7'h7F, 32'hC3C3_0003, 32'h0},
        '{3'd6, 1'b0, 7'h7F, 32'h0,         32'hC3C3_0003},
        '{3'd1, 1'b0, 7'h0D, 32'h0,         32'h0},
        '{3'd4, 1'b1, 7'h0D, 32'hD4D4_0004, 32'h0}
    };

    task automatic chk(input bit ok, input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic drive(input int p, input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
        req_valid[p] = 1'b1; req_we[p] = we; req_addr[p] = a; req_wdata[p] = d;
        tg = tg + 1'b1; req_tag[p] = tg;
    endtask

    // Lone request; checks arrival cycle, tag, ACK and data.
    task automatic single(input int p, input logic we, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, input logic [DW-1:0] exp, input string rq);
        logic [TAG_W-1:0] t;
        @(negedge clk);
        drive(p, we, a, d); t = tg;
        @(negedge clk); req_valid = '0;
        repeat (LAT - 2) @(negedge clk);
        chk(rsp_valid == '0, {rq, " R1 early"}, DW'(rsp_valid), 0);
        @(negedge clk);
        chk(rsp_valid == N'(1 << p), {rq, " R1 valid"}, DW'(rsp_valid), DW'(1 << p));
        chk(rsp_ack[p], {rq, " R5 ack"}, DW'(rsp_ack[p]), 1);
        chk(rsp_tag[p] == t, {rq, " R2 tag"}, DW'(rsp_tag[p]), DW'(t));
        chk(rsp_rdata[p] == exp, {rq, " R3/R4 data"}, rsp_rdata[p], exp);
        if (we) ref_mem[a] = d;
    endtask

    // Two simultaneous requests from pa (upper input) and pb; a_first picks the phase.
    task automatic pair(input int pa, input int pb, input logic we,
                        input logic [AW-1:0] aa, input logic [AW-1:0] ab,
                        input logic [DW-1:0] da, input logic [DW-1:0] db,
                        input int stage, input bit a_first, input string rq);
        bit a_wins;
        @(negedge clk);
        if ((((cyc + stage) % 2) == 0) != a_first) @(negedge clk);
        a_wins = ((cyc + stage) % 2) == 0;
        drive(pa, we, aa, da);
        drive(pb, we, ab, db);
        @(negedge clk); req_valid = '0;
        repeat (LAT - 1) @(negedge clk);
        chk(rsp_valid[pa] && rsp_valid[pb], {rq, " R1 both answered"}, DW'(rsp_valid), 0);
        chk(rsp_ack[pa] == a_wins, {rq, " R8 winner a"}, DW'(rsp_ack[pa]), DW'(a_wins));
        chk(rsp_ack[pb] == !a_wins, {rq, " R7 one nack"}, DW'(rsp_ack[pb]), DW'(!a_wins));
        if (a_wins) begin
            chk(rsp_rdata[pa] == ref_mem[aa], {rq, " R3 data"}, rsp_rdata[pa], ref_mem[aa]);
            if (we) ref_mem[aa] = da;
        end else begin
            chk(rsp_rdata[pb] == ref_mem[ab], {rq, " R3 data"}, rsp_rdata[pb], ref_mem[ab]);
            if (we) ref_mem[ab] = db;
        end
    endtask

    bit               busy [N];
    int               tiss [N], ops [N];
    logic             cwe  [N];
    logic [AW-1:0]    cad  [N];
    logic [DW-1:0]    cwd  [N];
    logic [TAG_W-1:0] ctg  [N];

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL R10 watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        int done;
        for (int i = 0; i < 128; i++) ref_mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(rsp_valid == '0 && rsp_ack == '0, "R1 reset outputs", DW'(rsp_valid), 0);
        rst_n = 1'b1;

        // Table of lone accesses
        for (int v = 0; v < 8; v++) begin
            single(int'(VEC[v].port), VEC[v].we, VEC[v].addr, VEC[v].wdata, VEC[v].exp, $sformatf("vec%0d", v));
        end

        // R6: identity permutation
        @(negedge clk);
        for (int p = 0; p < N; p++) drive(p, 1'b0, AW'(p), '0);
        @(negedge clk); req_valid = '0;
        repeat (LAT - 1) @(negedge clk);
        chk(rsp_ack == '1, "R6 all acked", DW'(rsp_ack), DW'(8'hFF));
        for (int p = 0; p < N; p++)
            chk(rsp_rdata[p] == ref_mem[p], "R6 data", rsp_rdata[p], ref_mem[p]);

        // R7/R8: first-column clash, both phases, loser write must not land
        pair(0, 4, 1'b1, 7'h07, 7'h07, 32'h1111_0000, 32'h4444_0000, 0, 1'b1, "R7 col0 p0");
        single(3, 1'b0, 7'h07, '0, ref_mem[7'h07], "R7 readback");
        pair(0, 4, 1'b1, 7'h07, 7'h07, 32'h1111_0001, 32'h4444_0001, 0, 1'b0, "R7 col0 p1");
        single(3, 1'b0, 7'h07, '0, ref_mem[7'h07], "R7 readback");
        // R8: middle and last column clashes
        pair(0, 2, 1'b0, 7'h17, 7'h17, '0, '0, 1, 1'b1, "R8 col1 p0");
        pair(0, 2, 1'b0, 7'h17, 7'h17, '0, '0, 1, 1'b0, "R8 col1 p1");
        pair(0, 1, 1'b0, 7'h27, 7'h27, '0, '0, 2, 1'b1, "R8 col2 p0");
        pair(0, 1, 1'b0, 7'h27, 7'h27, '0, '0, 2, 1'b0, "R8 col2 p1");
        // R9: different banks, shared switch output
        pair(0, 4, 1'b0, 7'h01, 7'h03, '0, '0, 0, 1'b1, "R9 internal block");

        // R10: random traffic with retry
        for (int p = 0; p < N; p++) begin busy[p] = 0; ops[p] = 0; end
        done = 0;
        while (done < N * OPS) begin
            @(negedge clk);
            for (int p = 0; p < N; p++) begin
                bit go;
                go = 0;
                if (busy[p]) begin
                    if (rsp_valid[p]) begin
                        chk(cyc - tiss[p] == LAT, "R10 latency", DW'(cyc - tiss[p]), LAT);
                        chk(rsp_tag[p] == ctg[p], "R10 tag", DW'(rsp_tag[p]), DW'(ctg[p]));
                        if (rsp_ack[p]) begin
                            chk(rsp_rdata[p] == ref_mem[cad[p]], "R10 data", rsp_rdata[p], ref_mem[cad[p]]);
                            if (cwe[p]) ref_mem[cad[p]] = cwd[p];
                            busy[p] = 0; ops[p]++; done++;
                        end else go = 1;
                    end else if (cyc - tiss[p] > LAT) begin
                        chk(0, "R10 lost response", DW'(cyc - tiss[p]), LAT);
                        busy[p] = 0; ops[p]++; done++;
                    end
                end else begin
                    chk(!rsp_valid[p], "R10 unsolicited", DW'(rsp_valid[p]), 0);
                end
                if (!busy[p] && ops[p] < OPS) begin
                    cwe[p] = 1'($urandom_range(0, 1));
                    cad[p] = AW'($urandom_range(0, 31));
                    cwd[p] = $urandom;
                    busy[p] = 1; go = 1;
                end
                if (go) begin
                    drive(p, cwe[p], cad[p], cwd[p]);
                    ctg[p] = tg; tiss[p] = cyc;
                end else req_valid[p] = 1'b0;
            end
        end
        @(negedge clk); req_valid = '0;
        repeat (LAT + 2) @(negedge clk);
        chk(rsp_valid == '0, "R1 drained", DW'(rsp_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule